// File: doc/BRIEF.md
# Coprocessor Boot Mailbox Sequencer

This block runs on the host side and brings a remote processor up through a small mailbox register file that the remote boot firmware also reads and writes. A single start pulse launches the whole bring-up. The block publishes the boot image address and polls until the first-stage boot code reports success. It then polls until the second-stage loader says it has unlocked protection. After that it clears the code length register, passes the metadata buffer address with a metadata command, and waits for header authentication. Finally it passes the code start address, a load command and the total length, and waits for full authentication.

Each waiting phase has its own expected status and its own limit, counted in ticks of a 1 ms strobe. When a phase fails, the block stops and latches an error code naming the phase and the cause, together with the last status word it read. The done and error flags stay set until the next start pulse.

Top module: `cop_boot_seq`

## Requirements
- R1: After reset, `done`, `error`, `busWr` and `busRd` are low and `errCode` is 0.
- R2: On a successful run, the block makes exactly seven mailbox writes and never asserts a write and a read in the same cycle. In order, the writes are: image address to 0x00, zero to 0x18, metadata address to 0x10, command 1 to 0x08, code start to 0x14, command 2 to 0x08, and code length to 0x18. The address and length values are the ones present on the inputs at the start pulse.
- R3: The primary status at 0x04 is polled while it reads zero. The value 1 moves on to the next phase. Any other non-zero value ends the run with kind "bad status" in phase 0, and `errStatus` holds that value.
- R4: The loader status at 0x0C is then polled while it reads zero. The values 1 and 2 are both accepted. Any other non-negative, non-zero value ends the run with kind "bad status" in phase 1.
- R5: In any loader-status wait (phases 1, 2 and 3), a value with bit 31 set ends the run at once with kind "negative status". `errStatus` holds the value, and no further mailbox writes follow.
- R6: In the metadata wait (phase 2), only the value 3 completes the phase. Other non-negative values keep the block polling.
- R7: In the image wait (phase 3), only the value 4 completes the phase and raises `done`. Other non-negative values keep the block polling.
- R8: A wait whose status stays unaccepted fails with kind "timeout". The failure comes after the phase limit in `msTick` pulses, and at most one tick later. The limits are the parameters `T_PRIMARY`, `T_LOADER`, `T_META` and `T_IMAGE`.
- R9: `errCode` is {phase[1:0], kind[1:0]}. The phase is 0 for primary, 1 for loader, 2 for metadata and 3 for image. The kind is 1 for timeout, 2 for bad status and 3 for negative status. `done` and `error` are never high together.
- R10: `done`, `error`, `errCode` and `errStatus` hold until the next start pulse. The cycle after a start pulse, `done` and `error` are low.
- R11: A start pulse during a run is ignored: the run completes with the same seven writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin bring-up |
| msTick | input | 1 | One-cycle pulse every millisecond |
| imgAddr | input | DATA_W | Boot image address, captured at start |
| metaAddr | input | DATA_W | Metadata buffer address, captured at start |
| codeAddr | input | DATA_W | Code start address, captured at start |
| codeLen | input | DATA_W | Total code length, captured at start |
| busWr | output | 1 | Mailbox write strobe |
| busRd | output | 1 | Mailbox read strobe |
| busAddr | output | 8 | Mailbox byte offset |
| busWdata | output | DATA_W | Mailbox write data |
| busRdata | input | DATA_W | Mailbox read data, valid the cycle after busRd |
| done | output | 1 | Bring-up completed |
| error | output | 1 | Bring-up failed |
| errCode | output | 4 | {phase, kind} of the failure |
| errStatus | output | DATA_W | Last status word read when the failure occurred |

## Verification
The bench goes after status classification in each phase. A negative value in the first loader wait must be reported as "negative", not "bad". The value 2 must be accepted there, and a non-matching positive value in the metadata or image wait must keep the block polling rather than failing it. A design that mixed these up would latch the wrong kind, or stop on a value the firmware is still allowed to report. The bench also checks the order of the last three writes, since a length written before the load command would let the firmware start on a stale length. It checks the tick window of a timeout, where an off-by-one counter would fail one tick early. Finally, it checks that a second start pulse during a run neither restarts the run nor clears the flags.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int MBX_AW = 8;

  localparam logic [MBX_AW-1:0] OFF_IMG  = 8'h00;
  localparam logic [MBX_AW-1:0] OFF_PBL  = 8'h04;
  localparam logic [MBX_AW-1:0] OFF_CMD  = 8'h08;
  localparam logic [MBX_AW-1:0] OFF_LDR  = 8'h0C;
  localparam logic [MBX_AW-1:0] OFF_META = 8'h10;
  localparam logic [MBX_AW-1:0] OFF_CODE = 8'h14;
  localparam logic [MBX_AW-1:0] OFF_LEN  = 8'h18;

  typedef enum logic [1:0] {PH_PRIMARY, PH_LOADER, PH_META, PH_IMAGE} phase_e;
  typedef enum logic [1:0] {EK_NONE, EK_TIMEOUT, EK_BADSTAT, EK_NEGSTAT} errkind_e;
  typedef enum logic [2:0] {
    SRC_IMG, SRC_ZERO, SRC_META, SRC_CMD_META, SRC_CODE, SRC_CMD_LOAD, SRC_LEN
  } wsrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              wr;
    logic              rd;
    logic [MBX_AW-1:0] addr;
    wsrc_e             src;
    logic              timerClr;
    logic              capture;
    logic              setDone;
    logic              setErr;
    errkind_e          kind;
  } strobe_t;
endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] rdData,
  input  logic              expired,
  output phase_e            curPhase,
  output strobe_t           stb
);
  typedef enum logic [3:0] {
    S_IDLE, S_IMG, S_PBL_RD, S_PBL_CHK, S_LDR_RD, S_LDR_CHK, S_CLRLEN, S_META,
    S_CMD1, S_META_RD, S_META_CHK, S_CODE, S_CMD2, S_LEN, S_AUTH_RD, S_AUTH_CHK
  } state_e;

  state_e st, nxt;
  logic   isNeg;
  logic   isZero;

  assign isNeg  = rdData[DATA_W-1];
  assign isZero = (rdData == '0);

  always_comb begin
    case (st)
      S_LDR_RD, S_LDR_CHK:   curPhase = PH_LOADER;
      S_META_RD, S_META_CHK: curPhase = PH_META;
      S_AUTH_RD, S_AUTH_CHK: curPhase = PH_IMAGE;
      default:               curPhase = PH_PRIMARY;
    endcase
  end

  always_comb begin
    stb = '0;
    nxt = st;
    case (st)
      S_IDLE: if (start) begin stb.capture = 1'b1; nxt = S_IMG; end
      S_IMG: begin
        stb.wr = 1'b1; stb.addr = OFF_IMG; stb.src = SRC_IMG;
        stb.timerClr = 1'b1; nxt = S_PBL_RD;
      end
      S_PBL_RD: begin stb.rd = 1'b1; stb.addr = OFF_PBL; nxt = S_PBL_CHK; end
      S_PBL_CHK: begin
        if (rdData == DATA_W'(1)) begin stb.timerClr = 1'b1; nxt = S_LDR_RD; end
        else if (!isZero) begin stb.setErr = 1'b1; stb.kind = EK_BADSTAT; nxt = S_IDLE; end
        else if (expired) begin stb.setErr = 1'b1; stb.kind = EK_TIMEOUT; nxt = S_IDLE; end
        else nxt = S_PBL_RD;
      end
      S_LDR_RD: begin stb.rd = 1'b1; stb.addr = OFF_LDR; nxt = S_LDR_CHK; end
      S_LDR_CHK: begin
        if (isNeg) begin stb.setErr = 1'b1; stb.kind = EK_NEGSTAT; nxt = S_IDLE; end
        else if (rdData == DATA_W'(1) || rdData == DATA_W'(2)) nxt = S_CLRLEN;
        else if (!isZero) begin stb.setErr = 1'b1; stb.kind = EK_BADSTAT; nxt = S_IDLE; end
        else if (expired) begin stb.setErr = 1'b1; stb.kind = EK_TIMEOUT; nxt = S_IDLE; end
        else nxt = S_LDR_RD;
      end
      S_CLRLEN: begin stb.wr = 1'b1; stb.addr = OFF_LEN; stb.src = SRC_ZERO; nxt = S_META; end
      S_META:   begin stb.wr = 1'b1; stb.addr = OFF_META; stb.src = SRC_META; nxt = S_CMD1; end
      S_CMD1: begin
        stb.wr = 1'b1; stb.addr = OFF_CMD; stb.src = SRC_CMD_META;
        stb.timerClr = 1'b1; nxt = S_META_RD;
      end
      S_META_RD: begin stb.rd = 1'b1; stb.addr = OFF_LDR; nxt = S_META_CHK; end
      S_META_CHK: begin
        if (isNeg) begin stb.setErr = 1'b1; stb.kind = EK_NEGSTAT; nxt = S_IDLE; end
        else if (rdData == DATA_W'(3)) nxt = S_CODE;
        else if (expired) begin stb.setErr = 1'b1; stb.kind = EK_TIMEOUT; nxt = S_IDLE; end
        else nxt = S_META_RD;
      end
      S_CODE: begin stb.wr = 1'b1; stb.addr = OFF_CODE; stb.src = SRC_CODE; nxt = S_CMD2; end
      S_CMD2: begin stb.wr = 1'b1; stb.addr = OFF_CMD; stb.src = SRC_CMD_LOAD; nxt = S_LEN; end
      S_LEN: begin
        stb.wr = 1'b1; stb.addr = OFF_LEN; stb.src = SRC_LEN;
        stb.timerClr = 1'b1; nxt = S_AUTH_RD;
      end
      S_AUTH_RD: begin stb.rd = 1'b1; stb.addr = OFF_LDR; nxt = S_AUTH_CHK; end
      S_AUTH_CHK: begin
        if (isNeg) begin stb.setErr = 1'b1; stb.kind = EK_NEGSTAT; nxt = S_IDLE; end
        else if (rdData == DATA_W'(4)) begin stb.setDone = 1'b1; nxt = S_IDLE; end
        else if (expired) begin stb.setErr = 1'b1; stb.kind = EK_TIMEOUT; nxt = S_IDLE; end
        else nxt = S_AUTH_RD;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end
endmodule

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int T_PRIMARY = 1000,
  parameter int T_LOADER  = 5000,
  parameter int T_META    = 1000,
  parameter int T_IMAGE   = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  strobe_t           stb,
  input  phase_e            curPhase,
  input  logic [DATA_W-1:0] imgAddr,
  input  logic [DATA_W-1:0] metaAddr,
  input  logic [DATA_W-1:0] codeAddr,
  input  logic [DATA_W-1:0] codeLen,
  input  logic [DATA_W-1:0] rdData,
  output logic              expired,
  output logic              busWr,
  output logic              busRd,
  output logic [MBX_AW-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              done,
  output logic              error,
  output logic [3:0]        errCode,
  output logic [DATA_W-1:0] errStatus
);
  localparam int T_AB  = (T_PRIMARY > T_LOADER) ? T_PRIMARY : T_LOADER;
  localparam int T_CD  = (T_META > T_IMAGE) ? T_META : T_IMAGE;
  localparam int T_MAX = (T_AB > T_CD) ? T_AB : T_CD;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(T_MAX);

  logic [CNT_W-1:0]  tickCnt, limit;
  logic [DATA_W-1:0] imgQ, metaQ, codeQ, lenQ;

  always_comb begin
    case (curPhase)
      PH_PRIMARY: limit = CNT_W'(T_PRIMARY);
      PH_LOADER:  limit = CNT_W'(T_LOADER);
      PH_META:    limit = CNT_W'(T_META);
      default:    limit = CNT_W'(T_IMAGE);
    endcase
  end

  assign expired = (tickCnt >= limit);

  always_ff @(posedge clk) begin
    if (!rstN || stb.timerClr) tickCnt <= '0;
    else if (msTick && tickCnt != CNT_TOP) tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      imgQ <= '0; metaQ <= '0; codeQ <= '0; lenQ <= '0;
    end else if (stb.capture) begin
      imgQ <= imgAddr; metaQ <= metaAddr; codeQ <= codeAddr; lenQ <= codeLen;
    end
  end

  assign busWr   = stb.wr;
  assign busRd   = stb.rd;
  assign busAddr = stb.addr;

  always_comb begin
    case (stb.src)
      SRC_IMG:      busWdata = imgQ;
      SRC_META:     busWdata = metaQ;
      SRC_CMD_META: busWdata = DATA_W'(1);
      SRC_CODE:     busWdata = codeQ;
      SRC_CMD_LOAD: busWdata = DATA_W'(2);
      SRC_LEN:      busWdata = lenQ;
      default:      busWdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.capture) begin
      done <= 1'b0; error <= 1'b0; errCode <= '0; errStatus <= '0;
    end else if (stb.setDone) begin
      done <= 1'b1;
    end else if (stb.setErr) begin
      error     <= 1'b1;
      errCode   <= {curPhase, stb.kind};
      errStatus <= rdData;
    end
  end
endmodule

// File: rtl/cop_boot_seq.sv
module cop_boot_seq
  import boot_seq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int T_PRIMARY = 1000,
  parameter int T_LOADER  = 5000,
  parameter int T_META    = 1000,
  parameter int T_IMAGE   = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              msTick,
  input  logic [DATA_W-1:0] imgAddr,
  input  logic [DATA_W-1:0] metaAddr,
  input  logic [DATA_W-1:0] codeAddr,
  input  logic [DATA_W-1:0] codeLen,
  output logic              busWr,
  output logic              busRd,
  output logic [7:0]        busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  output logic              done,
  output logic              error,
  output logic [3:0]        errCode,
  output logic [DATA_W-1:0] errStatus
);
  strobe_t stb;
  phase_e  curPhase;
  logic    expired;

  boot_seq_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .rdData(busRdata),
    .expired(expired), .curPhase(curPhase), .stb(stb)
  );

  boot_seq_dp #(
    .DATA_W(DATA_W), .T_PRIMARY(T_PRIMARY), .T_LOADER(T_LOADER),
    .T_META(T_META), .T_IMAGE(T_IMAGE)
  ) uDp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .stb(stb), .curPhase(curPhase),
    .imgAddr(imgAddr), .metaAddr(metaAddr), .codeAddr(codeAddr), .codeLen(codeLen),
    .rdData(busRdata), .expired(expired),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .done(done), .error(error), .errCode(errCode), .errStatus(errStatus)
  );
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              done,
  input logic              error,
  input logic [3:0]        errCode,
  input logic [DATA_W-1:0] errStatus
);
  a_r2_rw_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busRd));

  a_r2_cmd_values: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 8'h08) |-> (busWdata == DATA_W'(1) || busWdata == DATA_W'(2)));

  a_r2_len_after_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 8'h08 && busWdata == DATA_W'(2)) |=> (busWr && busAddr == 8'h18));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    (error && !start) |=> (error && $stable(errCode) && $stable(errStatus)));

  a_r5_neg_kind: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(error) && errStatus[DATA_W-1] && errCode[3:2] != 2'd0) |-> (errCode[1:0] == 2'd3));
endmodule

bind cop_boot_seq boot_seq_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busWr(busWr), .busRd(busRd),
  .busAddr(busAddr), .busWdata(busWdata), .done(done), .error(error),
  .errCode(errCode), .errStatus(errStatus)
);

// File: tb/sim_cop_boot_seq.sv
module sim_cop_boot_seq;
  localparam int TP = 6, TL = 8, TM = 5, TI = 9;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, msTick = 1'b0, mdlClr = 1'b0;
  logic [31:0] imgAddr = '0, metaAddr = '0, codeAddr = '0, codeLen = '0;
  logic busWr, busRd, done, error;
  logic [7:0] busAddr;
  logic [31:0] busWdata, busRdata, errStatus;
  logic [3:0] errCode;

  int nChk = 0, nBad = 0, tickCount = 0;
  logic [31:0] pblResp, bootResp, metaResp, authResp, pblReg, ldrReg, rdReg;
  int pblDelay = 6, pblCnt = -1, logN = 0;
  logic [7:0]  logA [16];
  logic [31:0] logD [16];

  always #2 clk = ~clk;

  cop_boot_seq #(.DATA_W(32), .T_PRIMARY(TP), .T_LOADER(TL), .T_META(TM), .T_IMAGE(TI)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .msTick(msTick),
    .imgAddr(imgAddr), .metaAddr(metaAddr), .codeAddr(codeAddr), .codeLen(codeLen),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .done(done), .error(error), .errCode(errCode), .errStatus(errStatus)
  );

  assign busRdata = rdReg;

  // mailbox and firmware model
  always @(posedge clk) begin
    if (mdlClr) begin
      pblReg <= '0; ldrReg <= '0; rdReg <= '0; logN <= 0; pblCnt <= -1;
    end else begin
      if (busRd) rdReg <= (busAddr == 8'h04) ? pblReg : (busAddr == 8'h0C) ? ldrReg : 32'h0;
      if (pblCnt == 0) begin pblReg <= pblResp; ldrReg <= bootResp; end
      if (pblCnt >= 0) pblCnt <= pblCnt - 1;
      if (busWr) begin
        if (logN < 16) begin logA[logN] <= busAddr; logD[logN] <= busWdata; end
        logN <= logN + 1;
        if (busAddr == 8'h00) pblCnt <= pblDelay;
        if (busAddr == 8'h08 && busWdata == 32'd1) ldrReg <= metaResp;
        if (busAddr == 8'h08 && busWdata == 32'd2) ldrReg <= authResp;
      end
    end
  end

  always @(posedge clk) if (msTick) tickCount <= tickCount + 1;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      msTick = 1'b1;
      @(negedge clk);
      msTick = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int tStart, tEnd;

  task automatic run(input logic [31:0] img, meta, code, len,
                     input logic [31:0] pR, bR, mR, aR, input bit midStart);
    int n;
    pblResp = pR; bootResp = bR; metaResp = mR; authResp = aR;
    imgAddr = img; metaAddr = meta; codeAddr = code; codeLen = len;
    @(negedge clk); mdlClr = 1'b1;
    @(negedge clk); mdlClr = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    tStart = tickCount;
    chk(!done && !error, "R10 flags cleared after start", {done, error}, 0);
    if (midStart) begin
      imgAddr = 32'hDEAD0000;
      repeat (3) begin
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
    end
    n = 0;
    while (!(done || error) && n < 4000) begin @(negedge clk); n++; end
    tEnd = tickCount;
    chk(n < 4000, "R2 run finished", n, 4000);
  endtask

  task automatic chkWrites(input logic [31:0] img, meta, code, len, input string req);
    logic [7:0]  ea [7];
    logic [31:0] ed [7];
    ea = '{8'h00, 8'h18, 8'h10, 8'h08, 8'h14, 8'h08, 8'h18};
    ed = '{img, 32'd0, meta, 32'd1, code, 32'd2, len};
    chk(logN == 7, {req, " write count"}, logN, 7);
    for (int i = 0; i < 7; i++)
      chk(logA[i] == ea[i] && logD[i] == ed[i], {req, " write order/value"},
          {logA[i], logD[i]}, {ea[i], ed[i]});
  endtask

  task automatic chkErr(input logic [3:0] code, input string req);
    chk(error && !done, {req, " error flag"}, {done, error}, 1);
    chk(errCode == code, {req, " errCode"}, errCode, code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !error && errCode == 4'd0 && !busWr && !busRd, "R1 reset state",
        {done, error, errCode, busWr, busRd}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !error && !busWr && !busRd, "R1 idle after reset", {done, error, busWr, busRd}, 0);

    // R2/R4/R7 success sweep over address patterns and both unlock codes
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a;
      a = 32'h1000_0000 * (k + 1) + 32'h40 * k;
      pblDelay = 2 + 3 * k;
      run(a, a + 32'h100, a + 32'h2000, 32'h300 + 32'h10 * k, 1, (k % 2) ? 2 : 1, 3, 4, 0);
      chk(done && !error, "R7 done after status 4", {done, error}, 2);
      chkWrites(a, a + 32'h100, a + 32'h2000, 32'h300 + 32'h10 * k, "R2");
    end
    // R10 hold of done
    repeat (20) @(negedge clk);
    chk(done && !error, "R10 done held", {done, error}, 2);

    pblDelay = 6;
    // R3 unexpected primary status
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 5, 1, 3, 4, 0);
    chkErr(4'b00_10, "R3");
    chk(errStatus == 32'd5, "R3 errStatus", errStatus, 5);
    chk(logN == 1, "R3 no write after failure", logN, 1);
    // R3 negative primary status is a bad status
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 32'h8000_0001, 1, 3, 4, 0);
    chkErr(4'b00_10, "R3 negative primary");

    // R8 primary timeout and its tick window
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 0, 1, 3, 4, 0);
    chkErr(4'b00_01, "R8 primary timeout");
    chk(tEnd - tStart >= TP && tEnd - tStart <= TP + 1, "R8 primary tick window", tEnd - tStart, TP);

    // R4 bad loader unlock status, loader timeout
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 1, 7, 3, 4, 0);
    chkErr(4'b01_10, "R4");
    chk(errStatus == 32'd7, "R4 errStatus", errStatus, 7);
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 1, 0, 3, 4, 0);
    chkErr(4'b01_01, "R8 loader timeout");

    // R5 negative in loader wait
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 1, 32'hFFFF_FFF0, 3, 4, 0);
    chkErr(4'b01_11, "R5 loader negative");
    chk(errStatus == 32'hFFFF_FFF0 && logN == 1, "R5 status and writes", {errStatus, logN}, 1);

    // R6 metadata: other value keeps waiting until timeout
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 1, 1, 2, 4, 0);
    chkErr(4'b10_01, "R6 metadata wait");
    chk(logN == 4, "R6 no code writes", logN, 4);
    chk(tEnd - tStart > TM, "R6 polled past other value", tEnd - tStart, TM);
    // R5 negative in metadata wait
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 1, 1, 32'h8000_0005, 4, 0);
    chkErr(4'b10_11, "R5 metadata negative");
    chk(errStatus == 32'h8000_0005, "R5 metadata errStatus", errStatus, 32'h8000_0005);

    // R7 image wait: 3 is not completion
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 1, 1, 3, 3, 0);
    chkErr(4'b11_01, "R7 image timeout");
    chk(logN == 7, "R7 all writes made", logN, 7);
    run(32'hA0, 32'hB0, 32'hC0, 32'h10, 1, 2, 3, 32'h8000_0000, 0);
    chkErr(4'b11_11, "R5 image negative");
    // R10 error held
    repeat (15) @(negedge clk);
    chkErr(4'b11_11, "R10 error held");

    // R11 start ignored mid-run
    run(32'h5000_0000, 32'h5100_0000, 32'h5200_0000, 32'h777, 1, 1, 3, 4, 1);
    chk(done && !error, "R11 completes", {done, error}, 2);
    chkWrites(32'h5000_0000, 32'h5100_0000, 32'h5200_0000, 32'h777, "R11");

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule